// File: doc/BRIEF.md
# Signal Timing Window Watchdog

This block supervises a single off-chip digital line and flags it when its timing leaves a programmed window. In period mode it counts the clock cycles from one active edge to the next; in width mode it counts the cycles an active pulse lasts, from its active edge to its inactive edge. A result below the lower bound, or above the upper bound, is a violation. The counter stops at the upper bound, so a line that has stopped toggling is caught as soon as the bound is reached. There is no need to wait for an edge that may never come.

The line passes through a two-flop synchronizer before edges are detected, and the active level can be chosen. Software programs the mode, polarity and both bounds through a small register port. It reads a sticky status word that it clears by writing ones. A violation also produces a one-cycle pulse for a fault controller and a level interrupt request toward the processor.

Top module: `sigwd_top`

## Requirements
- R1: While CTRL bit 0 (enable) is 0, no violation is detected, `fault_evt_o` stays low and STAT does not change, whatever the input does.
- R2: With CTRL bit 1 = 0 (period mode), the measurement is the number of clock cycles between two consecutive active edges, and a measurement with min <= m <= max is accepted silently.
- R3: With CTRL bit 1 = 1 (width mode), the measurement is the number of clock cycles from an active edge to the following inactive edge, and a measurement inside [min, max] is accepted silently.
- R4: A measurement below min sets STAT bits 1 and 0. A measurement above max sets STAT bits 2 and 0. A single measurement never sets both.
- R5: When a measurement reaches max cycles without its ending edge, a too-long violation is raised once, without waiting for an edge. Measuring then stops until the next active edge, which starts a new measurement without a check.
- R6: CTRL bit 2 = 0 makes the rising edge active; CTRL bit 2 = 1 makes the falling edge active and a low pulse the measured one.
- R7: The first active edge after enable only starts a measurement; an inactive edge seen before it is ignored.
- R8: The STAT bits are sticky: writing 1 to a STAT bit clears it, and writing 0 leaves it unchanged.
- R9: Each violation gives exactly one single-cycle pulse on `fault_evt_o`; `irq_o` is high while STAT bit 0 is set and CTRL bit 3 (interrupt enable) is 1.
- R10: Register addresses: 0 CTRL, 1 lower bound, 2 upper bound, 3 STAT. `cfg_rdata` shows the register selected by `cfg_addr` one cycle later, and all registers reset to 0 except the upper bound, which resets to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | CNT_W | Register write data |
| cfg_rdata | output | CNT_W | Registered read data |
| sig_i | input | 1 | Monitored asynchronous line |
| fault_evt_o | output | 1 | One-cycle pulse per violation |
| irq_o | output | 1 | Interrupt request, sticky error gated by enable |

## Verification
On every cycle, the assertions check the following:
- that a disabled monitor stays silent;
- that a single measurement never reports both too short and too long;
- that the first active edge after an idle phase never produces a check;
- that the error bit stays set until a one is written to it;
- that every violation pulse sets it;
- that the interrupt only rises when interrupt enable is set.

Only the bench scenarios can show that measured cycle counts are exact. Those scenarios cover bounds met exactly, bounds missed by one, the stuck-line timeout firing once, the polarity choice, and the counts of fault pulses over trains of pulses in both modes.

// File: rtl/sigwd_pkg.sv
package sigwd_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_LOW  = 2'd1;
  localparam logic [ADDR_W-1:0] A_HIGH = 2'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

  localparam int CTRL_W = 4;
  localparam int STAT_W = 3;

  typedef struct packed {
    logic irq_en;
    logic act_low;
    logic width_mode;
    logic enable;
  } ctrl_t;

  typedef enum logic {
    M_IDLE = 1'b0,
    M_RUN  = 1'b1
  } meter_st_e;

endpackage

// File: rtl/sigwd_sync.sv
module sigwd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);

  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_q <= '0;
    end else begin
      pipe_q[0] <= sig_i;
      for (int i = 1; i < DEPTH; i++) begin
        pipe_q[i] <= pipe_q[i-1];
      end
    end
  end

  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o = ~pipe_q[STAGES-1] & pipe_q[STAGES];

endmodule

// File: rtl/sigwd_meter.sv
module sigwd_meter
  import sigwd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable_i,
  input  logic             width_mode_i,
  input  logic             act_edge_i,
  input  logic             inact_edge_i,
  input  logic [CNT_W-1:0] low_i,
  input  logic [CNT_W-1:0] high_i,
  output logic             short_o,
  output logic             long_o
);

  meter_st_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             end_edge;

  assign end_edge = width_mode_i ? inact_edge_i : act_edge_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= M_IDLE;
      cnt_q   <= '0;
      short_o <= 1'b0;
      long_o  <= 1'b0;
    end else begin
      short_o <= 1'b0;
      long_o  <= 1'b0;
      if (!enable_i) begin
        st_q  <= M_IDLE;
        cnt_q <= '0;
      end else begin
        case (st_q)
          M_IDLE: begin
            if (act_edge_i) begin
              st_q  <= M_RUN;
              cnt_q <= CNT_W'(1);
            end
          end
          M_RUN: begin
            if (end_edge) begin
              short_o <= (cnt_q < low_i);
              long_o  <= (cnt_q > high_i);
              if (width_mode_i) begin
                st_q  <= M_IDLE;
                cnt_q <= '0;
              end else begin
                cnt_q <= CNT_W'(1);
              end
            end else if (cnt_q >= high_i) begin
              long_o <= 1'b1;
              st_q   <= M_IDLE;
              cnt_q  <= '0;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          default: begin
            st_q  <= M_IDLE;
            cnt_q <= '0;
          end
        endcase
      end
    end
  end

  assert_one_kind_R4: assert property (@(posedge clk) disable iff (rst)
    !(short_o && long_o));

  assert_first_edge_free_R7: assert property (@(posedge clk) disable iff (rst)
    (st_q == M_IDLE && enable_i && act_edge_i) |=> !(short_o || long_o));

  assert_quiet_off_R1: assert property (@(posedge clk) disable iff (rst)
    (!enable_i && !$past(enable_i)) |-> !(short_o || long_o));

endmodule

// File: rtl/sigwd_regs.sv
module sigwd_regs
  import sigwd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic              short_i,
  input  logic              long_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  low_o,
  output logic [CNT_W-1:0]  high_o,
  output logic              irq_o
);

  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  low_q;
  logic [CNT_W-1:0]  high_q;
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] stat_set;
  logic [STAT_W-1:0] stat_clr;
  logic [STAT_W-1:0] stat_n;
  logic [CNT_W-1:0]  rd_n;
  logic              stat_wr;

  assign stat_wr  = we_i && (addr_i == A_STAT);
  assign stat_set = {long_i, short_i, short_i | long_i};
  assign stat_clr = stat_wr ? wdata_i[STAT_W-1:0] : '0;
  assign stat_n   = (stat_q & ~stat_clr) | stat_set;

  always_comb begin
    rd_n = '0;
    case (addr_i)
      A_CTRL:  rd_n[CTRL_W-1:0] = ctrl_q;
      A_LOW:   rd_n = low_q;
      A_HIGH:  rd_n = high_q;
      default: rd_n[STAT_W-1:0] = stat_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      low_q   <= '0;
      high_q  <= '1;
      stat_q  <= '0;
      irq_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      if (we_i && addr_i == A_CTRL) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (we_i && addr_i == A_LOW)  low_q  <= wdata_i;
      if (we_i && addr_i == A_HIGH) high_q <= wdata_i;
      stat_q  <= stat_n;
      irq_o   <= stat_n[0] && ctrl_q.irq_en;
      rdata_o <= rd_n;
    end
  end

  assign ctrl_o = ctrl_q;
  assign low_o  = low_q;
  assign high_o = high_q;

  assert_sticky_err_R8: assert property (@(posedge clk) disable iff (rst)
    (stat_q[0] && !(stat_wr && wdata_i[0])) |=> stat_q[0]);

  assert_viol_sets_err_R4: assert property (@(posedge clk) disable iff (rst)
    (short_i || long_i) |=> stat_q[0]);

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(ctrl_q.irq_en));

endmodule

// File: rtl/sigwd_top.sv
module sigwd_top
  import sigwd_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  output logic [CNT_W-1:0] cfg_rdata,
  input  logic             sig_i,
  output logic             fault_evt_o,
  output logic             irq_o
);

  ctrl_t            ctrl;
  logic [CNT_W-1:0] low_b;
  logic [CNT_W-1:0] high_b;
  logic             rise;
  logic             fall;
  logic             act_edge;
  logic             inact_edge;
  logic             v_short;
  logic             v_long;
  logic             evt_q;

  sigwd_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rst    (rst),
    .sig_i  (sig_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign act_edge   = ctrl.act_low ? fall : rise;
  assign inact_edge = ctrl.act_low ? rise : fall;

  sigwd_meter #(.CNT_W(CNT_W)) meter_i (
    .clk          (clk),
    .rst          (rst),
    .enable_i     (ctrl.enable),
    .width_mode_i (ctrl.width_mode),
    .act_edge_i   (act_edge),
    .inact_edge_i (inact_edge),
    .low_i        (low_b),
    .high_i       (high_b),
    .short_o      (v_short),
    .long_o       (v_long)
  );

  sigwd_regs #(.CNT_W(CNT_W)) regs_i (
    .clk     (clk),
    .rst     (rst),
    .we_i    (cfg_we),
    .addr_i  (cfg_addr),
    .wdata_i (cfg_wdata),
    .rdata_o (cfg_rdata),
    .short_i (v_short),
    .long_i  (v_long),
    .ctrl_o  (ctrl),
    .low_o   (low_b),
    .high_o  (high_b),
    .irq_o   (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) evt_q <= 1'b0;
    else     evt_q <= v_short | v_long;
  end

  assign fault_evt_o = evt_q;

endmodule

// File: tb/sigwd_top_tb_top.sv
module sigwd_top_tb_top;

  localparam int W = 16;

  typedef struct packed {
    logic        mode;
    logic        pol;
    logic [15:0] lo_b;
    logic [15:0] hi_b;
    logic [15:0] t_act;
    logic [15:0] t_idle;
    logic [7:0]  n;
    logic [2:0]  exp_stat;
    logic [7:0]  exp_evt;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 16'd8,  16'd12, 16'd5, 16'd5, 8'd4, 3'b000, 8'd0}, // R2 ok
    '{1'b0, 1'b0, 16'd12, 16'd20, 16'd5, 16'd5, 8'd4, 3'b011, 8'd3}, // R4 short
    '{1'b0, 1'b0, 16'd4,  16'd8,  16'd6, 16'd9, 8'd3, 3'b101, 8'd3}, // R5 timeout
    '{1'b1, 1'b0, 16'd4,  16'd6,  16'd5, 16'd6, 8'd3, 3'b000, 8'd0}, // R3 ok
    '{1'b1, 1'b0, 16'd6,  16'd9,  16'd3, 16'd6, 8'd3, 3'b011, 8'd3}, // R3 short
    '{1'b1, 1'b0, 16'd2,  16'd4,  16'd8, 16'd6, 8'd2, 3'b101, 8'd2}, // R5 width
    '{1'b0, 1'b1, 16'd8,  16'd12, 16'd5, 16'd5, 8'd3, 3'b000, 8'd0}, // R6 period
    '{1'b1, 1'b1, 16'd6,  16'd9,  16'd3, 16'd6, 8'd2, 3'b011, 8'd2}, // R6 width
    '{1'b0, 1'b0, 16'd10, 16'd10, 16'd5, 16'd5, 8'd3, 3'b000, 8'd0}, // R2 edge
    '{1'b1, 1'b0, 16'd5,  16'd5,  16'd5, 16'd6, 8'd2, 3'b000, 8'd0}, // R3 edge
    '{1'b1, 1'b0, 16'd2,  16'd5,  16'd6, 16'd6, 8'd1, 3'b101, 8'd1}, // R4 max+1
    '{1'b0, 1'b0, 16'd11, 16'd14, 16'd5, 16'd5, 8'd2, 3'b011, 8'd1}  // R4 min-1
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_we = 1'b0;
  logic [1:0]   cfg_addr = '0;
  logic [W-1:0] cfg_wdata = '0;
  logic [W-1:0] cfg_rdata;
  logic         sig_i = 1'b0;
  logic         fault_evt_o;
  logic         irq_o;

  int n_chk = 0;
  int n_fail = 0;
  int evt_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sigwd_top #(.CNT_W(W)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .sig_i       (sig_i),
    .fault_evt_o (fault_evt_o),
    .irq_o       (irq_o)
  );

  always @(negedge clk) if (!rst && fault_evt_o) evt_cnt++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  // ctrl bits: 0 enable, 1 width mode, 2 active low, 3 irq enable
  task automatic run(input logic mode, input logic pol, input logic ien,
                     input logic [15:0] lo_b, input logic [15:0] hi_b,
                     input int t_act, input int t_idle, input int n,
                     output logic [W-1:0] stat, output int evts);
    int e0;
    logic [W-1:0] c;
    c = W'({ien, pol, mode, 1'b0});
    wr(2'd0, c);
    wr(2'd1, lo_b);
    wr(2'd2, hi_b);
    @(negedge clk); sig_i = pol;
    idle(4);
    wr(2'd3, W'(7));
    e0 = evt_cnt;
    wr(2'd0, c | W'(1));
    idle(2);
    for (int i = 0; i < n; i++) begin
      sig_i = ~pol;
      idle(t_act);
      sig_i = pol;
      if (i < n - 1) idle(t_idle);
      else idle(4);
    end
    wr(2'd0, c);
    idle(3);
    rd(2'd3, stat);
    evts = evt_cnt - e0;
  endtask

  initial begin
    logic [W-1:0] rv;
    int ev;
    idle(4);
    rst = 1'b0;
    idle(2);
    // reset state, R10
    rd(2'd0, rv); check("R10 ctrl reset", rv, 0);
    rd(2'd2, rv); check("R10 high bound reset", rv, 16'hFFFF);
    rd(2'd3, rv); check("R10 stat reset", rv, 0);
    check("R9 irq reset", irq_o, 0);
    wr(2'd1, 16'h1234);
    rd(2'd1, rv); check("R10 low bound readback", rv, 16'h1234);

    // vector table
    for (int v = 0; v < NV; v++) begin
      run(VECS[v].mode, VECS[v].pol, 1'b1, VECS[v].lo_b, VECS[v].hi_b,
          int'(VECS[v].t_act), int'(VECS[v].t_idle), int'(VECS[v].n), rv, ev);
      check($sformatf("R2/R3/R4/R5/R6 vec%0d stat", v), rv, W'(VECS[v].exp_stat));
      check($sformatf("R9 vec%0d events", v), ev, int'(VECS[v].exp_evt));
      check($sformatf("R9 vec%0d irq", v), irq_o, (VECS[v].exp_stat != 0));
    end

    // R8: stat now 011 from last vector
    wr(2'd3, W'(0));
    rd(2'd3, rv); check("R8 write zero keeps", rv, 3);
    wr(2'd3, W'(2));
    rd(2'd3, rv); check("R8 clear bit1 only", rv, 1);
    wr(2'd3, W'(1));
    rd(2'd3, rv); check("R8 clear err", rv, 0);
    idle(1);
    check("R9 irq drops after clear", irq_o, 0);

    // R5: stuck line raises one timeout only
    run(1'b0, 1'b0, 1'b1, 16'd8, 16'd12, 40, 5, 1, rv, ev);
    check("R5 stuck stat", rv, 5);
    check("R5 stuck single event", ev, 1);

    // R9: interrupt enable off
    run(1'b0, 1'b0, 1'b0, 16'd12, 16'd20, 5, 5, 3, rv, ev);
    check("R9 stat with irq off", rv, 3);
    check("R9 events with irq off", ev, 2);
    check("R9 irq gated", irq_o, 0);

    // R1: disabled monitor ignores short pulses
    wr(2'd3, W'(7));
    wr(2'd0, W'(4'b1000));
    wr(2'd1, W'(20));
    wr(2'd2, W'(30));
    ev = evt_cnt;
    for (int i = 0; i < 6; i++) begin
      sig_i = 1'b1; idle(2); sig_i = 1'b0; idle(2);
    end
    idle(4);
    rd(2'd3, rv); check("R1 disabled stat", rv, 0);
    check("R1 disabled events", evt_cnt - ev, 0);

    // R7: inactive edge before first active edge is ignored (width mode)
    wr(2'd0, W'(4'b1010));
    wr(2'd1, W'(5));
    wr(2'd2, W'(9));
    @(negedge clk); sig_i = 1'b1;
    idle(4);
    ev = evt_cnt;
    wr(2'd0, W'(4'b1011));
    idle(2);
    sig_i = 1'b0;
    idle(6);
    wr(2'd0, W'(4'b1010));
    idle(3);
    rd(2'd3, rv); check("R7 first edge not checked", rv, 0);
    check("R7 no event", evt_cnt - ev, 0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule